// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes to a card over one shared, open-drain I/O line. Each character is framed as a low start bit, eight data bits and an even parity bit. The data bits go out least significant first or most significant first. After the parity bit the block releases the line and listens for a low pulse from the card that reports a parity error. If that pulse arrives, the block raises a sticky error flag and sends the same byte again on its own. It keeps retrying until the card accepts the character. Only a clean character raises the transfer-end flag and its one-cycle interrupt pulse.

Bytes enter through a valid/ready port. The block takes a byte on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` then stays low for the whole character and any retries. A source that is held off keeps its byte and `wr_valid` asserted. `wr_ready` returns high in the same cycle that the transfer-end flag rises. The bit time is a whole number of system clocks set by `cfg_etu_clks`. Bit order and guard mode are captured when the byte is loaded.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, `wr_ready`=1, `tx_end`=1, `tx_err`=0, `tx_end_irq`=0 and `line_drive_low`=0 (line released).
- R2: A byte is taken on an edge with `wr_valid`=1 and `wr_ready`=1. From the next cycle `wr_ready`=0 and `tx_end`=0 until the character completes cleanly. A byte offered while `wr_ready`=0 is not taken and goes out only after the current character.
- R3: The start bit (`line_drive_low`=1, meaning line low) begins in the cycle after acceptance. Every bit lasts E clocks, where E = max(`cfg_etu_clks`, 4).
- R4: With `cfg_msb_first`=0, data bit 0 is sent first and bit 7 last. With `cfg_msb_first`=1, bit 7 is sent first and bit 0 last. A data bit of 1 releases the line.
- R5: The tenth bit slot carries even parity: its value is the XOR of the eight data bits.
- R6: From 10E clocks after the start bit begins, and whenever idle, the line is released.
- R7: `line_in` is sampled 10E+E/2 clocks after the start. If it is low, `tx_err` is 1 from the next cycle and `tx_end` stays 0 for that attempt.
- R8: After an error, the same byte is sent again, and its start bit begins exactly 13E clocks after the previous start. This repeats until an attempt is clean.
- R9: With `cfg_guard_ext`=0, a clean attempt sets `tx_end`=1 and `wr_ready`=1 exactly 11E clocks after its start bit began.
- R10: With `cfg_guard_ext`=1, a clean attempt sets `tx_end` exactly 12E+E/2 clocks after its start.
- R11: `tx_end_irq` is a one-cycle pulse in the first cycle that `tx_end` is high after a clean transfer.
- R12: `tx_err` stays set until an `err_clr` pulse clears it. If a detected error and `err_clr` fall on the same edge, the flag ends up set.
- R13: A `cfg_etu_clks` value below 4 gives a bit time of 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered |
| wr_ready | output | 1 | Block can take a byte (idle) |
| wr_data | input | 8 | Byte to send |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_guard_ext | input | 1 | 1: transfer end at 12.5 bit times, 0: at 11 |
| cfg_etu_clks | input | 12 | System clocks per bit time (minimum 4) |
| err_clr | input | 1 | Pulse to clear the error flag |
| line_in | input | 1 | Sensed level of the I/O line |
| line_drive_low | output | 1 | 1 pulls the I/O line low, 0 releases it |
| tx_end | output | 1 | Transfer-end flag |
| tx_err | output | 1 | Sticky error-signal flag |
| tx_end_irq | output | 1 | One-cycle transfer-end interrupt |

## Verification
The bench sends the same byte in both bit orders. A design that ignores the order setting, or reverses it, returns a mismatched byte. It also sends a byte with an odd number of ones, so a design with odd parity or a missing parity bit fails the parity slot.

The bench's card model pulls the line low in the error window once on one character and twice on another. A design that sets the end flag anyway, restarts at the wrong time, or sends a different byte on retry gets caught. The end flag is timed to the exact clock in both guard modes.

Further tests clamp the bit time to its minimum and clear the error flag on the same edge that an error is detected. A back-to-back transfer checks that a byte held off by back-pressure is neither lost nor sent early.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  // smallest legal bit time in system clocks
  localparam int MIN_ETU_CLKS = 4;

  // even parity bit for an arbitrary-width word
  function automatic logic even_parity(input logic [31:0] word, input int width);
    logic p;
    p = 1'b0;
    for (int i = 0; i < width; i++) p = p ^ word[i];
    return p;
  endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [ETU_W-1:0] etu_clks,
  output logic [IDX_W-1:0] etu_idx,
  output logic             etu_last,
  output logic             etu_mid,
  output logic             etu_pre_mid
);
  import sc_tx_pkg::*;

  logic [ETU_W-1:0] lim, half, cnt;

  always_comb begin
    lim  = (etu_clks < ETU_W'(MIN_ETU_CLKS)) ? ETU_W'(MIN_ETU_CLKS) : etu_clks;
    half = lim >> 1;
  end

  assign etu_last    = (cnt == lim - ETU_W'(1));
  assign etu_mid     = (cnt == half);
  assign etu_pre_mid = (cnt == half - ETU_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) begin
      cnt     <= '0;
      etu_idx <= '0;
    end else if (etu_last) begin
      cnt <= '0;
      if (etu_idx != '1) etu_idx <= etu_idx + IDX_W'(1);
    end else begin
      cnt <= cnt + ETU_W'(1);
    end
  end
endmodule

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_msb,
  input  logic              shift,
  output logic              data_bit,
  output logic              parity_bit
);
  import sc_tx_pkg::*;

  logic [DATA_W-1:0] tsr;
  logic              msb_q;
  logic              par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsr   <= '0;
      msb_q <= 1'b0;
      par_q <= 1'b0;
    end else if (load) begin
      tsr   <= load_data;
      msb_q <= load_msb;
      par_q <= even_parity(32'(load_data), DATA_W);
    end else if (shift) begin
      tsr <= msb_q ? (tsr << 1) : (tsr >> 1);
    end
  end

  assign data_bit   = msb_q ? tsr[DATA_W-1] : tsr[0];
  assign parity_bit = par_q;
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_msb_first,
  input  logic              cfg_guard_ext,
  input  logic              err_clr,
  input  logic              line_in,
  input  logic [IDX_W-1:0]  etu_idx,
  input  logic              etu_last,
  input  logic              etu_mid,
  input  logic              etu_pre_mid,
  input  logic              data_bit,
  input  logic              parity_bit,
  output logic              busy,
  output logic              restart,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  output logic              sh_msb,
  output logic              sh_shift,
  output logic              wr_ready,
  output logic              line_drive_low,
  output logic              tx_end,
  output logic              tx_err,
  output logic              tx_end_irq
);
  // slot numbers, counted in bit times from the start bit
  localparam int IDX_PAR   = DATA_W + 1;
  localparam int IDX_ERR   = DATA_W + 2;
  localparam int IDX_LATE  = DATA_W + 4;

  logic [DATA_W-1:0] tdr_q;
  logic busy_q, guard_q, err_seen_q, tend_q, err_q, irq_q;
  logic accept, err_hit, done_ok, retry, cur_bit;

  assign accept  = wr_valid && !busy_q;
  assign err_hit = busy_q && (etu_idx == IDX_W'(IDX_ERR)) && etu_mid && !line_in;
  assign done_ok = busy_q && !err_seen_q &&
                   ((!guard_q && (etu_idx == IDX_W'(IDX_ERR))  && etu_last) ||
                    ( guard_q && (etu_idx == IDX_W'(IDX_LATE)) && etu_pre_mid));
  assign retry   = busy_q && err_seen_q && (etu_idx == IDX_W'(IDX_LATE)) && etu_last;

  always_comb begin
    if (etu_idx == '0)                      cur_bit = 1'b0;
    else if (etu_idx <= IDX_W'(DATA_W))     cur_bit = data_bit;
    else if (etu_idx == IDX_W'(IDX_PAR))    cur_bit = parity_bit;
    else                                    cur_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdr_q      <= '0;
      busy_q     <= 1'b0;
      guard_q    <= 1'b0;
      err_seen_q <= 1'b0;
      tend_q     <= 1'b1;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= done_ok;
      if (accept) begin
        tdr_q      <= wr_data;
        busy_q     <= 1'b1;
        guard_q    <= cfg_guard_ext;
        err_seen_q <= 1'b0;
        tend_q     <= 1'b0;
      end else begin
        if (done_ok) begin
          busy_q <= 1'b0;
          tend_q <= 1'b1;
        end
        if (err_hit)    err_seen_q <= 1'b1;
        else if (retry) err_seen_q <= 1'b0;
      end
      if (err_hit)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign busy           = busy_q;
  assign restart        = retry;
  assign sh_load        = accept || retry;
  assign sh_data        = accept ? wr_data : tdr_q;
  assign sh_msb         = cfg_msb_first;
  assign sh_shift       = busy_q && etu_last && (etu_idx != '0) && (etu_idx <= IDX_W'(DATA_W));
  assign wr_ready       = !busy_q;
  assign line_drive_low = busy_q && !cur_bit;
  assign tx_end         = tend_q;
  assign tx_err         = err_q;
  assign tx_end_irq     = irq_q;
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DATA_W = 8,
  parameter int ETU_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_msb_first,
  input  logic              cfg_guard_ext,
  input  logic [ETU_W-1:0]  cfg_etu_clks,
  input  logic              err_clr,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              tx_end,
  output logic              tx_err,
  output logic              tx_end_irq
);
  localparam int IDX_W = $clog2(DATA_W + 6);

  logic [IDX_W-1:0]  etu_idx;
  logic              etu_last, etu_mid, etu_pre_mid;
  logic              busy, restart, sh_load, sh_msb, sh_shift;
  logic [DATA_W-1:0] sh_data;
  logic              data_bit, parity_bit;

  sc_etu_timer #(.ETU_W(ETU_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(restart),
    .etu_clks(cfg_etu_clks), .etu_idx(etu_idx), .etu_last(etu_last),
    .etu_mid(etu_mid), .etu_pre_mid(etu_pre_mid)
  );

  sc_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(sh_data),
    .load_msb(sh_msb), .shift(sh_shift), .data_bit(data_bit),
    .parity_bit(parity_bit)
  );

  sc_tx_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .cfg_msb_first(cfg_msb_first), .cfg_guard_ext(cfg_guard_ext),
    .err_clr(err_clr), .line_in(line_in), .etu_idx(etu_idx),
    .etu_last(etu_last), .etu_mid(etu_mid), .etu_pre_mid(etu_pre_mid),
    .data_bit(data_bit), .parity_bit(parity_bit), .busy(busy),
    .restart(restart), .sh_load(sh_load), .sh_data(sh_data),
    .sh_msb(sh_msb), .sh_shift(sh_shift), .wr_ready(wr_ready),
    .line_drive_low(line_drive_low), .tx_end(tx_end), .tx_err(tx_err),
    .tx_end_irq(tx_end_irq)
  );
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic err_clr,
  input logic line_drive_low,
  input logic tx_end,
  input logic tx_err,
  input logic tx_end_irq
);
  a_r2_accept_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
  a_r2_accept_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_end);
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !line_drive_low);
  a_r7_err_not_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> !tx_end);
  a_r9_end_frees_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> wr_ready);
  a_r11_irq_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_irq |-> tx_end);
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_irq |=> !tx_end_irq);
  a_r11_end_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> tx_end_irq);
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !err_clr) |=> tx_err);
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .err_clr(err_clr), .line_drive_low(line_drive_low), .tx_end(tx_end),
  .tx_err(tx_err), .tx_end_irq(tx_end_irq)
);

// File: tb/tb_sc_char_tx.sv
module tb_sc_char_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = '0;
  logic        cfg_msb_first = 1'b0, cfg_guard_ext = 1'b0;
  logic [11:0] cfg_etu_clks = 12'd8;
  logic        err_clr = 1'b0, line_in, line_drive_low;
  logic        tx_end, tx_err, tx_end_irq;
  logic        card_low = 1'b0;
  bit          done = 1'b0;

  assign line_in = !(line_drive_low || card_low);

  sc_char_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .cfg_msb_first(cfg_msb_first),
    .cfg_guard_ext(cfg_guard_ext), .cfg_etu_clks(cfg_etu_clks),
    .err_clr(err_clr), .line_in(line_in), .line_drive_low(line_drive_low),
    .tx_end(tx_end), .tx_err(tx_err), .tx_end_irq(tx_end_irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  typedef struct {
    logic [7:0] d;
    logic       msb;
    logic       gm;
    int         e;
    int         errs;
    bit         clamped;
  } item_t;
  item_t expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver: pushes the expected character, then hands the byte over
  task automatic send(input logic [7:0] d, input logic msb, input logic gm,
                      input int etu_cfg, input int errs);
    item_t it;
    it.d = d; it.msb = msb; it.gm = gm; it.errs = errs;
    it.e = (etu_cfg < 4) ? 4 : etu_cfg;
    it.clamped = (etu_cfg < 4);
    expq.push_back(it);
    cfg_msb_first = msb;
    cfg_guard_ext = gm;
    cfg_etu_clks  = 12'(etu_cfg);
    wr_data  = d;
    wr_valid = 1'b1;
    forever begin
      if (wr_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R2 ready low after accept", wr_ready, 0);
    chk(tx_end == 1'b0, "R2 write clears end flag", tx_end, 0);
  endtask

  task automatic wait_idle();
    while (expq.size() != 0 || !wr_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: decodes each character on the line and compares with the queue
  initial begin : monitor
    item_t it;
    int t0, h, tend_at;
    logic [7:0] got;
    logic b;
    @(negedge clk);
    forever begin
      while (!line_drive_low) @(negedge clk);
      t0 = cyc;
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected start bit", 1, 0);
        while (line_drive_low) @(negedge clk);
        continue;
      end
      it = expq[0];
      forever begin
        h = it.e / 2;
        chk(line_drive_low == 1'b1, "R3 start bit low", line_drive_low, 1);
        wait_to(t0 + it.e - 1);
        chk(line_drive_low == 1'b1, "R3 start bit width", line_drive_low, 1);
        got = '0;
        for (int k = 0; k < 8; k++) begin
          wait_to(t0 + (k + 1) * it.e + h);
          b = !line_drive_low;
          if (it.msb) got[7 - k] = b;
          else        got[k]     = b;
        end
        chk(got == it.d, it.clamped ? "R13 data at clamped bit time" : "R4 data bits", got, it.d);
        wait_to(t0 + 9 * it.e + h);
        chk(!line_drive_low == ^it.d, "R5 even parity", !line_drive_low, ^it.d);
        wait_to(t0 + 10 * it.e);
        chk(line_drive_low == 1'b0, "R6 released after parity", line_drive_low, 0);
        if (it.errs > 0) begin
          card_low = 1'b1;
          wait_to(t0 + 10 * it.e + h);
          err_clr = 1'b1;
          @(negedge clk);
          err_clr = 1'b0;
          chk(tx_err == 1'b1, "R7 R12 error set beats clear", tx_err, 1);
          wait_to(t0 + 11 * it.e);
          chk(tx_end == 1'b0, "R7 no end after error", tx_end, 0);
          wait_to(t0 + 12 * it.e);
          card_low = 1'b0;
          chk(tx_err == 1'b1, "R12 error flag sticky", tx_err, 1);
          err_clr = 1'b1;
          @(negedge clk);
          err_clr = 1'b0;
          chk(tx_err == 1'b0, "R12 error flag cleared", tx_err, 0);
          wait_to(t0 + 12 * it.e + h + 1);
          chk(tx_end == 1'b0, "R7 no late end after error", tx_end, 0);
          wait_to(t0 + 13 * it.e - 1);
          chk(line_drive_low == 1'b0, "R8 line idle before retry", line_drive_low, 0);
          @(negedge clk);
          chk(line_drive_low == 1'b1, "R8 retry start at 13 etu", line_drive_low, 1);
          it.errs = it.errs - 1;
          expq[0].errs = it.errs;
          t0 = cyc;
        end else begin
          tend_at = it.gm ? (12 * it.e + h) : (11 * it.e);
          wait_to(t0 + tend_at - 1);
          chk(tx_end == 1'b0, it.gm ? "R10 end not early" : "R9 end not early", tx_end, 0);
          chk(line_drive_low == 1'b0, "R6 released in guard", line_drive_low, 0);
          @(negedge clk);
          chk(tx_end == 1'b1, it.clamped ? "R13 end at clamped time" :
              (it.gm ? "R10 end at 12.5 etu" : "R9 end at 11 etu"), tx_end, 1);
          chk(wr_ready == 1'b1, "R9 port free at end", wr_ready, 1);
          chk(tx_end_irq == 1'b1, "R11 irq with end", tx_end_irq, 1);
          @(negedge clk);
          chk(tx_end_irq == 1'b0, "R11 irq one cycle", tx_end_irq, 0);
          void'(expq.pop_front());
          break;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b1 && tx_end == 1'b1, "R1 reset ready and end", {wr_ready, tx_end}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_err == 1'b0, "R1 reset error flag", tx_err, 0);
    chk(tx_end_irq == 1'b0, "R1 reset irq", tx_end_irq, 0);
    chk(line_drive_low == 1'b0, "R1 R6 line released at idle", line_drive_low, 0);
    chk(tx_end == 1'b1, "R1 end flag after reset", tx_end, 1);

    send(8'hC1, 1'b0, 1'b0, 8, 0);  wait_idle();
    send(8'hC1, 1'b1, 1'b0, 8, 0);  wait_idle();
    send(8'h07, 1'b0, 1'b1, 10, 0); wait_idle();
    send(8'h5B, 1'b0, 1'b0, 8, 1);  wait_idle();
    send(8'hE2, 1'b1, 1'b1, 6, 2);  wait_idle();
    send(8'h81, 1'b0, 1'b0, 2, 0);  wait_idle();

    send(8'h12, 1'b0, 1'b0, 8, 0);
    chk(wr_ready == 1'b0, "R2 second byte held off", wr_ready, 0);
    send(8'hFE, 1'b0, 1'b0, 8, 0);
    wait_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule